// File: doc/BRIEF.md
# Power-Gated Virtual-Channel Input Buffer

This block is a single input virtual-channel buffer for an on-chip router. It stores flits in a small register-based FIFO. When the FIFO holds nothing, it switches its storage off to save leakage. Whenever the buffer is empty and the cycle is idle, it goes to sleep: it raises `sleep` and drops the power-switch enable `psw_en`.

A sleep ends when a flit arrives or when an early `wake_req` comes in, for example from a look-ahead routing stage one hop upstream. The buffer then turns the switch back on. For a programmable number of cycles it holds `ready` low, and during that time the router pipeline stage that reads this buffer must stall. A flit that arrives while the storage is unpowered is not lost. It waits in a one-entry staging register and is moved into the FIFO on the first powered cycle.

Three counters measure how well power gating is working: the number of sleep periods, the total cycles spent asleep, and the number of sleeps that ended before a programmable breakeven length. A sleep shorter than the breakeven length costs more energy to enter and leave than the leakage it saves. The breakeven length grows with clock frequency, so it is an input port rather than a constant.

Top module: `pg_vc_buffer`

## Requirements
- R1: While reset is held and just after it, the buffer is powered: `ready`=1, `psw_en`=1, `sleep`=0, `empty`=1, `full`=0, `wr_ready`=1, `rd_valid`=0. All three counters are zero.
- R2: When the buffer is powered, holds no flit and sees a cycle with neither `wr_valid` nor `wake_req`, it is asleep after that edge: `sleep`=1, `psw_en`=0, `ready`=0. `sleep_periods` then increases by one.
- R3: Suppose `wr_valid` or `wake_req` is high at edge E while the buffer sleeps. Then `sleep` falls after E, and `ready` rises after edge E+WAKE_DLY, not earlier. `rd_valid` is 0 whenever `ready` is 0.
- R4: A flit accepted while `ready`=0 is held in the staging register. It appears on `rd_flit` with `rd_valid`=1 one cycle after `ready` rises. While it is held, `wr_ready`=0, and a `wr_valid` in that state has no effect.
- R5: The buffer holds up to DEPTH flits and returns them in write order. With DEPTH stored, `full`=1 and `wr_ready`=0, and a further `wr_valid` stores nothing.
- R6: Each read, which is `rd_en` while `rd_valid`=1, gives a one-cycle `credit` pulse after the edge.
- R7: `sleep_cycles` increases by one for every clock edge at which the buffer is asleep.
- R8: The length of a sleep is the number of edges spent asleep, including the edge where it wakes. When a sleep ends with a length below `breakeven`, `short_sleeps` increases by one. A sleep whose length equals or exceeds `breakeven` leaves it unchanged.
- R9: While powered, `wake_req`=1 keeps an empty buffer awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Incoming flit valid |
| wr_flit | input | FLIT_W | Incoming flit |
| wr_ready | output | 1 | A write in this cycle is accepted |
| rd_en | input | 1 | Consume the head flit |
| rd_valid | output | 1 | Head flit present and storage powered |
| rd_flit | output | FLIT_W | Head flit |
| credit | output | 1 | One-cycle pulse per consumed flit, for the upstream sender |
| full | output | 1 | Stored flits equal DEPTH |
| empty | output | 1 | No flit stored or staged |
| wake_req | input | 1 | Early wakeup request; also holds the buffer awake |
| breakeven | input | CNT_W | Minimum sleep length that pays off |
| ready | output | 1 | Storage powered; 0 means the pipeline stalls |
| sleep | output | 1 | Storage asleep |
| psw_en | output | 1 | Power-switch enable |
| sleep_periods | output | CNT_W | Count of sleeps entered |
| sleep_cycles | output | CNT_W | Count of edges spent asleep |
| short_sleeps | output | CNT_W | Count of sleeps shorter than `breakeven` |

## Verification
Every output comes from a register, so each result is due right after the edge that consumes the stimulus. The exceptions are these:
- `ready` rises WAKE_DLY edges after the waking edge.
- A staged flit reaches `rd_flit` one edge after that.
- `credit` follows its read by one edge.

The bench drives inputs and samples outputs one nanosecond after each rising edge. It therefore compares the state produced by the edge just passed, counting the WAKE_DLY=2 wake window and the staging hop edge by edge. Sleep lengths of one, two, three and four edges are set against a breakeven of four, so both sides of the short-sleep threshold are covered.

// File: rtl/pg_vc_pkg.sv
package pg_vc_pkg;
   typedef enum logic [1:0] {
      PW_ON   = 2'd0,
      PW_OFF  = 2'd1,
      PW_WAKE = 2'd2
   } pw_state_e;
endpackage

// File: rtl/pg_vc_power_fsm.sv
module pg_vc_power_fsm
   import pg_vc_pkg::*;
#(
   parameter int WAKE_DLY = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      go_idle,
   input  logic      wake_evt,
   output pw_state_e state
);
   localparam int WCW = (WAKE_DLY > 1) ? $clog2(WAKE_DLY) : 1;

   pw_state_e state_q;
   assign state = state_q;

   generate
      if (WAKE_DLY == 0) begin : g_instant
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_q <= PW_ON;
            end else begin
               case (state_q)
                  PW_ON:   if (go_idle)  state_q <= PW_OFF;
                  PW_OFF:  if (wake_evt) state_q <= PW_ON;
                  default: state_q <= PW_ON;
               endcase
            end
         end
      end else begin : g_timed
         logic [WCW-1:0] wcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               state_q <= PW_ON;
               wcnt_q  <= '0;
            end else begin
               case (state_q)
                  PW_ON: if (go_idle) state_q <= PW_OFF;
                  PW_OFF: if (wake_evt) begin
                     state_q <= PW_WAKE;
                     wcnt_q  <= WCW'(WAKE_DLY - 1);
                  end
                  PW_WAKE: begin
                     if (wcnt_q == '0) state_q <= PW_ON;
                     else              wcnt_q  <= wcnt_q - 1'b1;
                  end
                  default: state_q <= PW_ON;
               endcase
            end
         end
      end
   endgenerate

   AST_WAKE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state_q == PW_ON) |-> $past(state_q == PW_OFF, WAKE_DLY + 1)); // R3
endmodule

// File: rtl/pg_vc_regfifo.sv
module pg_vc_regfifo #(
   parameter int W     = 64,
   parameter int DEPTH = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic                       pop,
   input  logic [W-1:0]               din,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << PW));

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wptr_q, rptr_q, wptr_nx, rptr_nx;
   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr_q + 1'b1;
         assign rptr_nx = rptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
         assign rptr_nx = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wptr_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= wptr_nx;
         if (pop)  rptr_q <= rptr_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rptr_q];
   assign count = cnt_q;

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/pg_vc_sleep_stats.sv
module pg_vc_sleep_stats #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             asleep,
   input  logic             enter,
   input  logic             leave,
   input  logic [CNT_W-1:0] breakeven,
   output logic [CNT_W-1:0] periods,
   output logic [CNT_W-1:0] cycles,
   output logic [CNT_W-1:0] shorts
);
   logic [CNT_W-1:0] slen_q;
   logic [CNT_W:0]   this_len;
   logic             is_short;

   assign this_len = {1'b0, slen_q} + 1'b1;
   assign is_short = this_len < {1'b0, breakeven};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slen_q  <= '0;
         periods <= '0;
         cycles  <= '0;
         shorts  <= '0;
      end else begin
         if (enter) begin
            slen_q  <= '0;
            periods <= periods + 1'b1;
         end else if (asleep && !(&slen_q)) begin
            slen_q <= slen_q + 1'b1;
         end
         if (asleep) cycles <= cycles + 1'b1;
         if (leave && is_short) shorts <= shorts + 1'b1;
      end
   end

   AST_SHORT_ONLY_AT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (shorts != $past(shorts)) |-> ($past(asleep) && !asleep)); // R8
   AST_CYCLES_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cycles != $past(cycles)) |-> $past(asleep)); // R7
endmodule

// File: rtl/pg_vc_buffer.sv
module pg_vc_buffer
   import pg_vc_pkg::*;
#(
   parameter int FLIT_W   = 64,
   parameter int DEPTH    = 4,
   parameter int WAKE_DLY = 2,
   parameter int CNT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [FLIT_W-1:0] wr_flit,
   output logic              wr_ready,
   input  logic              rd_en,
   output logic              rd_valid,
   output logic [FLIT_W-1:0] rd_flit,
   output logic              credit,
   output logic              full,
   output logic              empty,
   input  logic              wake_req,
   input  logic [CNT_W-1:0]  breakeven,
   output logic              ready,
   output logic              sleep,
   output logic              psw_en,
   output logic [CNT_W-1:0]  sleep_periods,
   output logic [CNT_W-1:0]  sleep_cycles,
   output logic [CNT_W-1:0]  short_sleeps
);
   localparam int CW = $clog2(DEPTH + 1);

   initial begin
      if (DEPTH < 2)                     $error("pg_vc_buffer: DEPTH must be at least 2");
      if (WAKE_DLY < 0 || WAKE_DLY > 3)  $error("pg_vc_buffer: WAKE_DLY must lie in 0..3");
      if (FLIT_W < 1 || CNT_W < 2)       $error("pg_vc_buffer: bad width");
   end

   pw_state_e        state;
   logic             powered, asleep;
   logic [CW-1:0]    fcnt;
   logic [CW-1:0]    occ;
   logic             stage_vld;
   logic [FLIT_W-1:0] stage_q;
   logic             wr_acc, push, pop, go_idle, wake_evt;
   logic             credit_q;

   assign powered  = (state == PW_ON);
   assign asleep   = (state == PW_OFF);
   assign occ      = fcnt + CW'(stage_vld);
   assign full     = (occ == CW'(DEPTH));
   assign empty    = (occ == '0);
   assign wr_ready = !full && !stage_vld;
   assign wr_acc   = wr_valid && wr_ready;
   assign push     = powered && (stage_vld || wr_acc);
   assign rd_valid = powered && (fcnt != '0);
   assign pop      = rd_en && rd_valid;
   assign go_idle  = (fcnt == '0) && !stage_vld && !wr_valid && !wake_req;
   assign wake_evt = wr_valid || wake_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_vld <= 1'b0;
         stage_q   <= '0;
         credit_q  <= 1'b0;
      end else begin
         credit_q <= pop;
         if (powered) begin
            stage_vld <= 1'b0;
         end else if (wr_acc) begin
            stage_vld <= 1'b1;
            stage_q   <= wr_flit;
         end
      end
   end

   pg_vc_power_fsm #(.WAKE_DLY(WAKE_DLY)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .go_idle  (go_idle),
      .wake_evt (wake_evt),
      .state    (state)
   );

   pg_vc_regfifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .pop   (pop),
      .din   (stage_vld ? stage_q : wr_flit),
      .dout  (rd_flit),
      .count (fcnt)
   );

   pg_vc_sleep_stats #(.CNT_W(CNT_W)) u_stats (
      .clk       (clk),
      .rst_n     (rst_n),
      .asleep    (asleep),
      .enter     (powered && go_idle),
      .leave     (asleep && wake_evt),
      .breakeven (breakeven),
      .periods   (sleep_periods),
      .cycles    (sleep_cycles),
      .shorts    (short_sleeps)
   );

   assign credit = credit_q;
   assign ready  = powered;
   assign sleep  = asleep;
   assign psw_en = !asleep;

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(fcnt) + 32'(stage_vld)) <= DEPTH); // R5
   AST_SLEEP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> (fcnt == '0)); // R2
   AST_STAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && !powered) |=> (stage_vld && $stable(stage_q))); // R4
   AST_STAGE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_vld && powered) |=> (fcnt != '0)); // R4
   AST_CREDIT_AFTER_POP: assert property (@(posedge clk) disable iff (!rst_n)
      credit |-> $past(rd_en && rd_valid)); // R6
   AST_AWAKE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (powered && wake_req) |=> !asleep); // R9
endmodule

// File: tb/tb_pg_vc_buffer.sv
module tb_pg_vc_buffer;
   localparam int FW = 64;
   localparam int CW = 16;
   localparam int D  = 2;   // wake delay used throughout the expected values

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_valid = 1'b0, rd_en = 1'b0, wake_req = 1'b0;
   logic [FW-1:0] wr_flit = '0;
   logic [CW-1:0] breakeven = 16'd4;
   logic wr_ready, rd_valid, credit, full, empty, ready, sleep, psw_en;
   logic [FW-1:0] rd_flit;
   logic [CW-1:0] sleep_periods, sleep_cycles, short_sleeps;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   pg_vc_buffer #(.FLIT_W(FW), .DEPTH(4), .WAKE_DLY(D), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_flit(wr_flit),
      .wr_ready(wr_ready), .rd_en(rd_en), .rd_valid(rd_valid), .rd_flit(rd_flit),
      .credit(credit), .full(full), .empty(empty), .wake_req(wake_req),
      .breakeven(breakeven), .ready(ready), .sleep(sleep), .psw_en(psw_en),
      .sleep_periods(sleep_periods), .sleep_cycles(sleep_cycles),
      .short_sleeps(short_sleeps)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic drive(input logic wv, input logic wk, input logic rd, input logic [7:0] b);
      wr_valid = wv; wake_req = wk; rd_en = rd; wr_flit = {8{b}};
   endtask

   // one sleep period of n edges, woken by wake_req, then D wake edges and one idle edge back to sleep
   task automatic sleep_run(input int n, input string req);
      for (int i = 0; i < n - 1; i++) begin
         drive(0, 0, 0, 8'h00); step();
      end
      drive(0, 1, 0, 8'h00); step();
      drive(0, 0, 0, 8'h00);
      for (int i = 0; i < D; i++) begin
         chk({req, " R3 not ready while waking"}, ready, 0);
         step();
      end
      chk({req, " R3 ready after wake delay"}, ready, 1);
      step();
      chk({req, " R2 back asleep"}, sleep, 1);
   endtask

   // rows: wv wk rd wbyte | ready sleep empty rd_valid rbyte
   localparam int NROW = 12;
   localparam logic [22:0] TBL [NROW] = '{
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b0,8'h00},  // R2 idle edge after reset
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b0,8'h00},  // R2 stays asleep
      {1'b1,1'b0,1'b0,8'hA1, 1'b0,1'b0,1'b0,1'b0,8'h00},  // R3 R4 flit wakes, staged
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b0,1'b0,8'h00},  // R3 waking
      {1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b0,8'h00},  // R3 ready at E+D
      {1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b0,1'b1,8'hA1},  // R4 staged flit readable
      {1'b0,1'b0,1'b1,8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00},  // R6 read it
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b0,8'h00},  // R2 sleeps again
      {1'b0,1'b1,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h00},  // R3 wake_req
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b0,1'b1,1'b0,8'h00},  // R3 waking
      {1'b0,1'b0,1'b0,8'h00, 1'b1,1'b0,1'b1,1'b0,8'h00},  // R3 ready
      {1'b0,1'b0,1'b0,8'h00, 1'b0,1'b1,1'b1,1'b0,8'h00}   // R2 sleep
   };

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1;
      chk("R1 ready", ready, 1);
      chk("R1 psw_en", psw_en, 1);
      chk("R1 sleep", sleep, 0);
      chk("R1 empty", empty, 1);
      chk("R1 full", full, 0);
      chk("R1 wr_ready", wr_ready, 1);
      chk("R1 rd_valid", rd_valid, 0);
      chk("R1 counters", {sleep_periods, sleep_cycles, short_sleeps}, 0);
      rst_n = 1'b1;

      for (int r = 0; r < NROW; r++) begin
         logic [22:0] v;
         v = TBL[r];
         drive(v[22], v[21], v[20], v[19:12]);
         step();
         chk($sformatf("R3 table row %0d ready", r), ready, v[11]);
         chk($sformatf("R2 table row %0d sleep", r), sleep, v[10]);
         chk($sformatf("R2 table row %0d psw_en", r), psw_en, !v[10]);
         chk($sformatf("R5 table row %0d empty", r), empty, v[9]);
         chk($sformatf("R3 table row %0d rd_valid", r), rd_valid, v[8]);
         if (v[8]) chk($sformatf("R4 table row %0d rd_flit", r), rd_flit, {8{v[7:0]}});
      end
      chk("R2 periods after table", sleep_periods, 3);
      chk("R8 shorts after table", short_sleeps, 2);
      chk("R7 cycles after table", sleep_cycles, 3);

      // R8 length equal to breakeven: not short
      sleep_run(4, "R8 len4");
      chk("R8 len4 not short", short_sleeps, 2);
      chk("R7 cycles len4", sleep_cycles, 7);
      chk("R2 periods len4", sleep_periods, 4);
      // R8 length one below breakeven: short
      sleep_run(3, "R8 len3");
      chk("R8 len3 short", short_sleeps, 3);
      chk("R7 cycles len3", sleep_cycles, 10);

      // R4 staging blocks a second write
      drive(1, 0, 0, 8'hC1); step();
      chk("R4 wr_ready low while staged", wr_ready, 0);
      chk("R4 not empty", empty, 0);
      drive(1, 0, 0, 8'hC2); step();
      drive(0, 0, 0, 8'h00); step();
      chk("R3 ready after staged wake", ready, 1);
      chk("R3 rd_valid waits for drain", rd_valid, 0);
      step();
      chk("R4 staged flit out", rd_flit, {8{8'hC1}});
      chk("R4 rd_valid", rd_valid, 1);
      chk("R4 wr_ready back", wr_ready, 1);
      drive(0, 0, 1, 8'h00); step();
      chk("R6 credit after read", credit, 1);
      chk("R4 second write dropped", empty, 1);
      chk("R4 nothing else stored", rd_valid, 0);
      drive(0, 0, 0, 8'h00); step();
      chk("R6 credit one cycle", credit, 0);
      chk("R2 sleep after drain", sleep, 1);
      chk("R8 shorts after staging", short_sleeps, 4);

      // R5 fill to depth and order
      drive(0, 1, 0, 8'h00); step();
      drive(0, 0, 0, 8'h00); step(); step();
      chk("R3 ready before fill", ready, 1);
      for (int i = 0; i < 4; i++) begin
         drive(1, 0, 0, 8'hB0 + 8'(i)); step();
      end
      chk("R5 full", full, 1);
      chk("R5 wr_ready low when full", wr_ready, 0);
      drive(1, 0, 0, 8'hEE); step();
      chk("R5 still full", full, 1);
      for (int i = 0; i < 4; i++) begin
         chk($sformatf("R5 order %0d", i), rd_flit, {8{8'hB0 + 8'(i)}});
         drive(0, 0, 1, 8'h00); step();
         chk($sformatf("R6 credit %0d", i), credit, 1);
      end
      chk("R5 empty after drain, overfill not stored", empty, 1);
      chk("R5 no extra flit", rd_valid, 0);
      drive(0, 1, 0, 8'h00); step();
      chk("R9 wake_req keeps awake", sleep, 0);
      chk("R9 ready held", ready, 1);
      drive(0, 0, 0, 8'h00); step();
      chk("R2 sleep after release", sleep, 1);
      chk("R2 periods final", sleep_periods, 7);
      chk("R8 shorts final", short_sleeps, 5);
      chk("R7 cycles final", sleep_cycles, 12);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule